// File: doc/BRIEF.md
# Register-Programmed PWM Output Generator

A bank of independent pulse-width modulators, each configured through a byte-wide register port that offers address, write data, a write strobe and a combinational read path. For every channel, software stores a 4-bit frequency code F and a 10-bit duty field D across two bytes. It then turns the channel on by setting that channel's bit in a shared enable byte. Each channel divides the fast input clock by (32 − F) to form one time quantum. Its output period is always 1024 quanta, and the output stays high for the first D + 1 quanta of every period.

Because D is stored minus one, the duty range runs from a single quantum up to a constantly high output. A constantly low output comes only from disabling the channel. New values written while a channel is running are held back until the current period ends, so the waveform never shows a truncated or stretched pulse. With a 9.6 MHz input clock the output frequency spans roughly 293 Hz (F = 0) to 551 Hz (F = 15).

Top module: `pwmgen_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and drives every output low from the cycle after the reset edge. This holds even when the reset arrives while channels are running.
- R2: Channel n's low byte sits at offset 0x60 + 2n and holds D[7:0]. Its high byte sits at 0x61 + 2n and holds D[9:8] in bits [1:0] and F in bits [7:4], with bits [3:2] reading back zero. The enable byte sits at 0x60 + 2·NUM_CH (0x66 with the default three channels), and bit n of it belongs to channel n. Its bits at or above NUM_CH read back zero.
- R3: Reads at offsets outside the defined set return zero, and writes there change no register.
- R4: One quantum lasts (32 − F) clock cycles, so the divider runs from 32 (F = 0) down to 17 (F = 15).
- R5: Every output period lasts exactly 1024 quanta, whatever the duty setting.
- R6: The output is high for (D + 1) quanta at the start of each period. A write that sets a clear enable bit restarts that channel, and the output is high in the first cycle after the write.
- R7: With D = 1023, an enabled channel's output stays high continuously.
- R8: While a channel's enable bit is clear, its output is low. A write that clears the bit brings the output low in the first cycle after the write.
- R9: Duty and frequency values written to a running channel take effect only at the next period boundary.
- R10: Writing 1 to an enable bit that is already set does not restart the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from which the quanta are derived |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Register offset for reads and writes |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_we | input | 1 | Write strobe; the write happens at the clock edge |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr, combinational |
| pwm_o | output | NUM_CH (3) | One PWM output per channel |

## Verification
The hardest situation to reach from the ports is a register write that lands inside a running period, whether it is a new duty value or a repeated enable. Its effect shows only as a timing difference one full period later. To reach it, the stimulus enables a channel with a one-quantum pulse and waits until the output is well into its low phase. It then rewrites the duty field and the enable bit, and measures the number of cycles from the original enable to the next rising edge and the width of the pulse that follows. A premature reload or a restart shows up as a wrong period or a wrong pulse width.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    // Default geometry shared by all modules of the generator.
    parameter int unsigned PG_DUTY_W = 10;
    parameter int unsigned PG_FREQ_W = 4;
    parameter int unsigned PG_DATA_W = 8;
    parameter int unsigned PG_ADDR_W = 8;
    parameter int unsigned PG_NUM_CH = 3;
    parameter int unsigned PG_BASE   = 'h60;

endpackage

// File: rtl/pwmgen_regfile.sv
module pwmgen_regfile
    import pwmgen_pkg::*;
#(
    parameter int NUM_CH    = PG_NUM_CH,
    parameter int ADDR_W    = PG_ADDR_W,
    parameter int DATA_W    = PG_DATA_W,
    parameter int DUTY_W    = PG_DUTY_W,
    parameter int FREQ_W    = PG_FREQ_W,
    parameter int BASE_ADDR = PG_BASE
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    input  logic                               bus_we,
    output logic [DATA_W-1:0]                  bus_rdata,
    output logic [NUM_CH-1:0][DUTY_W-1:0]      duty_o,
    output logic [NUM_CH-1:0][FREQ_W-1:0]      freq_o,
    output logic [NUM_CH-1:0]                  en_o,
    output logic [NUM_CH-1:0]                  start_o
);

    localparam int EN_ADDR  = BASE_ADDR + 2 * NUM_CH;
    localparam int HI_W     = DUTY_W - DATA_W;
    localparam int FREQ_LSB = DATA_W - FREQ_W;
    localparam int PAD_W    = FREQ_LSB - HI_W;

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] duty_lo;
        logic [NUM_CH-1:0][HI_W-1:0]   duty_hi;
        logic [NUM_CH-1:0][FREQ_W-1:0] freq;
        logic [NUM_CH-1:0]             en;
    } rf_t;

    rf_t  st_d, st_q;
    logic en_hit;

    function automatic logic [ADDR_W-1:0] lo_addr(input int n);
        return ADDR_W'(BASE_ADDR + 2 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int n);
        return ADDR_W'(BASE_ADDR + 2 * n + 1);
    endfunction

    // Next-state: byte writes into the channel fields and the enable mask.
    always_comb begin
        st_d    = st_q;
        start_o = '0;
        en_hit  = bus_we && (bus_addr == ADDR_W'(EN_ADDR));
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_we && (bus_addr == lo_addr(n))) begin
                st_d.duty_lo[n] = bus_wdata;
            end
            if (bus_we && (bus_addr == hi_addr(n))) begin
                st_d.duty_hi[n] = bus_wdata[HI_W-1:0];
                st_d.freq[n]    = bus_wdata[DATA_W-1:FREQ_LSB];
            end
        end
        if (en_hit) begin
            st_d.en = bus_wdata[NUM_CH-1:0];
            // only a 0 -> 1 transition restarts a channel
            start_o = bus_wdata[NUM_CH-1:0] & ~st_q.en;
        end
    end

    // Read path: defined offsets return stored fields, all others zero.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == lo_addr(n)) begin
                bus_rdata = st_q.duty_lo[n];
            end
            if (bus_addr == hi_addr(n)) begin
                bus_rdata = {st_q.freq[n], {PAD_W{1'b0}}, st_q.duty_hi[n]};
            end
        end
        if (bus_addr == ADDR_W'(EN_ADDR)) begin
            bus_rdata = DATA_W'(st_q.en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            duty_o[n] = {st_q.duty_hi[n], st_q.duty_lo[n]};
            freq_o[n] = st_q.freq[n];
        end
        en_o = st_q.en;
    end

endmodule

// File: rtl/pwmgen_quantum.sv
module pwmgen_quantum #(
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] lim_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } qs_t;

    qs_t st_d, st_q;

    // A tick marks the last input cycle of a quantum.
    assign tick_o = run_i && (st_q.pre == lim_i);

    always_comb begin
        st_d = st_q;
        if (!run_i || restart_i) begin
            st_d.pre = '0;
        end else if (tick_o) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwmgen_chan.sv
module pwmgen_chan
    import pwmgen_pkg::*;
#(
    parameter int DUTY_W = PG_DUTY_W,
    parameter int FREQ_W = PG_FREQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [DUTY_W-1:0] cfg_duty_i,
    input  logic [FREQ_W-1:0] cfg_freq_i,
    output logic              pwm_o,
    output logic [DUTY_W-1:0] qidx_o,
    output logic [DUTY_W-1:0] act_duty_o
);

    localparam int PRE_W   = FREQ_W + 1;
    localparam int DIV_TOP = 2 ** PRE_W;

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic [DUTY_W-1:0] act_duty;
        logic [PRE_W-1:0]  act_lim;
    } ch_t;

    ch_t              st_d, st_q;
    logic             tick;
    logic [PRE_W-1:0] lim_new;

    // prescaler terminal count = divider - 1 = (DIV_TOP - 1) - F
    assign lim_new = PRE_W'(DIV_TOP - 1) - PRE_W'(cfg_freq_i);

    pwmgen_quantum #(
        .PRE_W (PRE_W)
    ) quantum_i (
        .clk       (clk),
        .rst       (rst),
        .run_i     (en_i),
        .restart_i (start_i),
        .lim_i     (st_q.act_lim),
        .tick_o    (tick)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt      = '0;
            st_d.act_duty = cfg_duty_i;
            st_d.act_lim  = lim_new;
        end else if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == '1) begin
                // period boundary: pick up the shadowed configuration
                st_d.cnt      = '0;
                st_d.act_duty = cfg_duty_i;
                st_d.act_lim  = lim_new;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o      = en_i && (st_q.cnt <= st_q.act_duty);
    assign qidx_o     = st_q.cnt;
    assign act_duty_o = st_q.act_duty;

endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
#(
    parameter int NUM_CH    = PG_NUM_CH,
    parameter int ADDR_W    = PG_ADDR_W,
    parameter int DATA_W    = PG_DATA_W,
    parameter int DUTY_W    = PG_DUTY_W,
    parameter int FREQ_W    = PG_FREQ_W,
    parameter int BASE_ADDR = PG_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH-1:0][DUTY_W-1:0] duty_cfg;
    logic [NUM_CH-1:0][FREQ_W-1:0] freq_cfg;
    logic [NUM_CH-1:0]             en_mask;
    logic [NUM_CH-1:0]             start_vec;
    logic [NUM_CH-1:0][DUTY_W-1:0] qidx_vec;
    logic [NUM_CH-1:0][DUTY_W-1:0] act_vec;

    pwmgen_regfile #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DUTY_W    (DUTY_W),
        .FREQ_W    (FREQ_W),
        .BASE_ADDR (BASE_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .duty_o    (duty_cfg),
        .freq_o    (freq_cfg),
        .en_o      (en_mask),
        .start_o   (start_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwmgen_chan #(
            .DUTY_W (DUTY_W),
            .FREQ_W (FREQ_W)
        ) chan_i (
            .clk        (clk),
            .rst        (rst),
            .en_i       (en_mask[g]),
            .start_i    (start_vec[g]),
            .cfg_duty_i (duty_cfg[g]),
            .cfg_freq_i (freq_cfg[g]),
            .pwm_o      (pwm_o[g]),
            .qidx_o     (qidx_vec[g]),
            .act_duty_o (act_vec[g])
        );
    end

endmodule

// File: rtl/pwmgen_chk.sv
module pwmgen_chk #(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int DUTY_W    = 10,
    parameter int BASE_ADDR = 'h60
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic                          bus_we,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]             pwm_o,
    input logic [NUM_CH-1:0]             en_mask,
    input logic [NUM_CH-1:0]             start_vec,
    input logic [NUM_CH-1:0][DUTY_W-1:0] qidx_vec,
    input logic [NUM_CH-1:0][DUTY_W-1:0] act_vec
);

    localparam int EN_ADDR = BASE_ADDR + 2 * NUM_CH;

    logic en_wr;
    assign en_wr = bus_we && (bus_addr == ADDR_W'(EN_ADDR));

    // R3: undefined offsets read zero
    a_r3_undef_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ((int'(bus_addr) < BASE_ADDR) || (int'(bus_addr) > EN_ADDR)) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R8: a disabled channel never drives high
        a_r8_off_is_low: assert property (@(posedge clk) disable iff (rst)
            !en_mask[g] |-> !pwm_o[g]);

        // R8: clearing the enable bit drops the output after one edge
        a_r8_clear_fast: assert property (@(posedge clk) disable iff (rst)
            (en_wr && !bus_wdata[g]) |=> !pwm_o[g]);

        // R6: a restart begins at quantum zero with the output high
        a_r6_start_high: assert property (@(posedge clk) disable iff (rst)
            start_vec[g] |=> (pwm_o[g] && (qidx_vec[g] == '0)));

        // R5: while running, the quantum index holds or advances by one
        a_r5_index_step: assert property (@(posedge clk) disable iff (rst)
            (en_mask[g] && $past(en_mask[g])) |->
            ((qidx_vec[g] == $past(qidx_vec[g])) ||
             (qidx_vec[g] == DUTY_W'($past(qidx_vec[g]) + 1'b1))));

        // R10: rewriting a set enable bit causes no jump back to zero
        a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
            (en_wr && bus_wdata[g] && en_mask[g]) |=>
            ((qidx_vec[g] == $past(qidx_vec[g])) ||
             (qidx_vec[g] == DUTY_W'($past(qidx_vec[g]) + 1'b1))));

        // R9: the active duty changes only where a period starts
        a_r9_update_at_edge: assert property (@(posedge clk) disable iff (rst)
            (en_mask[g] && !$stable(act_vec[g])) |-> (qidx_vec[g] == '0));
    end

endmodule

bind pwmgen_top pwmgen_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DUTY_W    (DUTY_W),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwm_o     (pwm_o),
    .en_mask   (en_mask),
    .start_vec (start_vec),
    .qidx_vec  (qidx_vec),
    .act_vec   (act_vec)
);

// File: tb/pwmgen_top_tb_top.sv
module pwmgen_top_tb_top;

    localparam int NCH = 3;
    localparam int NV  = 4;
    // rows: channel, frequency code F, duty field D
    localparam int VEC [NV][3] = '{
        '{0, 15, 0},
        '{1,  8, 100},
        '{2,  0, 511},
        '{0, 14, 1022}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] pwm_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwmgen_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        d = int'(bus_rdata);
    endtask

    // Counts high samples, then low samples until the next rise.
    task automatic measure(input int ch, output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (pwm_o[ch] && hi < 40000) begin
            hi++;
            @(negedge clk);
        end
        while (!pwm_o[ch] && lo < 40000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int hi;
        int lo;
        int c0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 outputs after reset", int'(pwm_o), 0);
        for (int a = 'h60; a <= 'h66; a++) begin
            rd(8'(a), v);
            check("R1 register after reset", v, 0);
        end

        // R2: field layout and reserved bits
        wr(8'h65, 8'hFF);
        rd(8'h65, v);
        check("R2 high byte readback", v, 'hF3);
        wr(8'h64, 8'hA5);
        rd(8'h64, v);
        check("R2 low byte readback", v, 'hA5);
        wr(8'h66, 8'hF8);
        rd(8'h66, v);
        check("R2 enable bits above channel count", v, 0);
        check("R2 outputs stay low", int'(pwm_o), 0);

        // R3: undefined offsets
        wr(8'h67, 8'hFF);
        rd(8'h67, v);
        check("R3 read above map", v, 0);
        wr(8'h5F, 8'hFF);
        rd(8'h5F, v);
        check("R3 read below map", v, 0);
        rd(8'h65, v);
        check("R3 neighbour untouched", v, 'hF3);
        rd(8'h66, v);
        check("R3 enable untouched", v, 0);

        // R4 R5 R6: table of frequency and duty settings
        for (int i = 0; i < NV; i++) begin
            int ch;
            int f;
            int d;
            ch = VEC[i][0];
            f  = VEC[i][1];
            d  = VEC[i][2];
            wr(8'h66, 8'h00);
            wr(8'(8'h60 + 2 * ch), 8'(d & 'hFF));
            wr(8'(8'h61 + 2 * ch), 8'((f << 4) | (d >> 8)));
            wr(8'h66, 8'(1 << ch));
            measure(ch, hi, lo);
            check("R6 high time", hi, (d + 1) * (32 - f));
            check("R4 R5 period", hi + lo, 1024 * (32 - f));
        end
        wr(8'h66, 8'h00);

        // R9 R10: mid-period update and enable rewrite
        wr(8'h60, 8'h00);
        wr(8'h61, 8'hF0);
        wr(8'h66, 8'h01);
        c0 = cyc;
        measure(0, hi, lo);
        check("R6 first pulse before update", hi, 17);
        c0 = c0;
        // measure already ran to the next rise; redo with a mid-period write
        wr(8'h66, 8'h00);
        wr(8'h66, 8'h01);
        c0 = cyc;
        hi = 0;
        while (pwm_o[0] && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        repeat (200) @(negedge clk);
        wr(8'h60, 8'h09);
        wr(8'h66, 8'h01);
        check("R9 output low after mid-period write", int'(pwm_o[0]), 0);
        lo = 0;
        while (!pwm_o[0] && lo < 40000) begin
            lo++;
            @(negedge clk);
        end
        check("R10 R9 next rise one full period after enable", cyc - c0, 17408);
        measure(0, hi, lo);
        check("R9 new pulse width applied", hi, 170);
        wr(8'h66, 8'h00);

        // R7: full duty stays high
        wr(8'h62, 8'hFF);
        wr(8'h63, 8'hF3);
        wr(8'h66, 8'h02);
        hi = 0;
        for (int k = 0; k < 18000; k++) begin
            if (pwm_o[1]) hi++;
            @(negedge clk);
        end
        check("R7 constant high samples", hi, 18000);

        // R8: clearing the enable bit
        wr(8'h66, 8'h00);
        check("R8 low right after disable", int'(pwm_o[1]), 0);
        repeat (50) @(negedge clk);
        check("R8 low while disabled", int'(pwm_o), 0);

        // R1: reset while running
        wr(8'h66, 8'h02);
        check("R6 high right after enable", int'(pwm_o[1]), 1);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 outputs low after mid-run reset", int'(pwm_o), 0);
        rd(8'h66, v);
        check("R1 enable cleared by reset", v, 0);
        rd(8'h62, v);
        check("R1 duty cleared by reset", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule